// File: doc/BRIEF.md
# Host Controller for a Serially Programmed Sigma-Delta Converter

This block is the bus master for a two-wire link to an external converter. The link has one clock line driven by the host and one data line driven by the device, plus two channel-select lines. Each falling edge of the clock line has a meaning that depends on where the device is in its sequence. The first edge starts a conversion on the selected channel. Further edges sent inside a short window each remove one bit of resolution. Once the device reports completion, later edges shift the result out. The host turns a parallel request into that edge sequence. The request carries a channel and a resolution from 10 to 16 bits. The host hands back the signed result left-aligned in a 16-bit word, with a one-cycle valid strobe.

If the host loses track of the device, for example after its own reset in the middle of a read, a resynchronisation request makes it run high-low-high clock triples. In each triple it samples the data line once per phase. It stops when it sees the signature of a freshly started conversion. It then waits for that conversion, which runs at full resolution, and delivers the result. The clock high and low widths are parameters, and so are the window length, the conversion timeout and the resync attempt limit. The data line passes through a two-flop synchroniser.

Top module: `edge_conv_host`

## Requirements
- R1: During and right after reset, `dev_sclk` is 1 and `busy`, `result_valid`, `sync_done` and `timeout_err` are all 0.
- R2: `dev_addr` takes `req_chan` when a request is accepted and holds it, unchanged, for as long as `busy` is 1.
- R3: For a requested resolution R, clamped to the range 10..16, the host issues 16-R reduction falling edges after the start edge, never more than six. Every reduction edge falls while the window counter is below WINDOW_CYC. A complete convert-and-read cycle has exactly 17 falling edges.
- R4: Between the last reduction edge and the rise of the data line, `dev_sclk` stays at 1, so the device sees no falling edge while it converts.
- R5: The host captures R bits, one per falling edge, sign bit first, sampling near the end of each low phase. `result` holds the captured word in bits 15 down to 16-R, with zeros below. `result_valid` is high for exactly one cycle.
- R6: If the data line has not risen CONV_MAX cycles after waiting begins, `timeout_err` pulses for one cycle without `result_valid`. The host then returns to idle with `dev_sclk` at 1.
- R7: Each low phase of `dev_sclk` lasts at least LOW_CYC cycles, and each high phase before a falling edge lasts at least HIGH_CYC cycles.
- R8: A resync request runs high-low-high triples, sampling the data line at the end of each phase. A triple that reads 1,1,0 ends the search: `sync_done` pulses, and the 16-bit result of the conversion that was started is then delivered. Any other pattern leads to another triple. After SYNC_TRIES failed triples, `timeout_err` pulses instead.
- R9: A conversion request that arrives in the same cycle as a resync request is served, and the resync request is dropped. Requests of either kind are ignored while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Conversion request, sampled when idle |
| req_chan | input | 2 | Channel for a conversion or resync |
| req_res | input | 5 | Requested resolution in bits, clamped to 10..16 |
| sync_req | input | 1 | Resynchronisation request, sampled when idle |
| dev_sdat | input | 1 | Data line from the device |
| dev_sclk | output | 1 | Clock line to the device |
| dev_addr | output | 2 | Channel-select lines to the device |
| busy | output | 1 | High while a sequence is running |
| result | output | 16 | Left-aligned signed result |
| result_valid | output | 1 | One-cycle strobe when `result` is updated |
| sync_done | output | 1 | One-cycle pulse when the start signature is found |
| timeout_err | output | 1 | One-cycle pulse on a conversion or resync timeout |

## Verification
Two pairs of events can land in the same cycle. The first pair is a conversion request and a resync request. The bench raises both on the same idle cycle and checks three things: the result matches the requested channel and resolution, the clock shows the conversion's edge count, and `sync_done` never pulses. The second pair is a fresh request and a sequence already in flight. The bench raises a request with a different channel partway through a conversion and checks that the address lines keep the first channel and that exactly one valid strobe appears.

// File: rtl/edge_conv_host.sv
module edge_conv_host #(
  parameter int HIGH_CYC   = 6,
  parameter int LOW_CYC    = 6,
  parameter int WINDOW_CYC = 128,
  parameter int CONV_MAX   = 4096,
  parameter int SYNC_TRIES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic [1:0]  req_chan,
  input  logic [4:0]  req_res,
  input  logic        sync_req,
  input  logic        dev_sdat,
  output logic        dev_sclk,
  output logic [1:0]  dev_addr,
  output logic        busy,
  output logic [15:0] result,
  output logic        result_valid,
  output logic        sync_done,
  output logic        timeout_err
);
  localparam int PMAX = (HIGH_CYC > LOW_CYC) ? HIGH_CYC : LOW_CYC;
  localparam int PW   = $clog2(PMAX + 1);
  localparam int WW   = $clog2(WINDOW_CYC + 1);
  localparam int CW   = $clog2(CONV_MAX + 1);
  localparam int TW   = $clog2(SYNC_TRIES + 1);
  localparam logic [PW-1:0] P_HI     = PW'(HIGH_CYC - 1);
  localparam logic [PW-1:0] P_LO     = PW'(LOW_CYC - 1);
  localparam logic [WW-1:0] WIN_LAST = WW'(WINDOW_CYC - 1);
  localparam logic [WW-1:0] WIN_SAT  = WW'(WINDOW_CYC);
  localparam logic [CW-1:0] CNV_LAST = CW'(CONV_MAX - 1);
  localparam logic [TW-1:0] TRY_LAST = TW'(SYNC_TRIES - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_RHI, S_RLO, S_WAIT, S_DLO, S_DHI, S_YH1, S_YLO, S_YH2
  } st_t;

  st_t             state;
  logic [PW-1:0]   pcnt;
  logic [WW-1:0]   win;
  logic [CW-1:0]   wcnt;
  logic [TW-1:0]   tries;
  logic [2:0]      red_left, red_done;
  logic [4:0]      bit_left;
  logic [15:0]     shreg;
  logic [1:0]      sd_q;
  logic            samp_a, samp_b;

  wire sdat_s    = sd_q[1];
  wire phase_end = (pcnt == '0);
  wire in_red    = (state == S_RLO);
  wire in_wait   = (state == S_WAIT);
  wire in_sync   = (state == S_YH1) || (state == S_YLO) || (state == S_YH2);

  wire [2:0] red_req = (req_res >= 5'd16) ? 3'd0 :
                       (req_res <= 5'd10) ? 3'd6 : 3'(5'd16 - req_res);

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;  pcnt <= '0;  win <= '0;  wcnt <= '0;  tries <= '0;
      red_left <= '0;  red_done <= '0;  bit_left <= '0;  shreg <= '0;
      sd_q <= '0;  samp_a <= 1'b0;  samp_b <= 1'b0;
      dev_sclk <= 1'b1;  dev_addr <= '0;  result <= '0;
      result_valid <= 1'b0;  sync_done <= 1'b0;  timeout_err <= 1'b0;
    end else begin
      result_valid <= 1'b0;
      sync_done    <= 1'b0;
      timeout_err  <= 1'b0;
      sd_q <= {sd_q[0], dev_sdat};
      if (!phase_end) pcnt <= pcnt - 1'b1;
      if ((state == S_START || state == S_RHI || state == S_RLO) && win != WIN_SAT)
        win <= win + 1'b1;
      case (state)
        S_IDLE: begin
          if (req) begin
            dev_addr <= req_chan;  red_left <= red_req;  red_done <= '0;
            win <= '0;  dev_sclk <= 1'b0;  pcnt <= P_LO;  state <= S_START;
          end else if (sync_req) begin
            dev_addr <= req_chan;  tries <= '0;
            dev_sclk <= 1'b1;  pcnt <= P_HI;  state <= S_YH1;
          end
        end
        S_START, S_RLO: if (phase_end) begin
          dev_sclk <= 1'b1;  pcnt <= P_HI;  state <= S_RHI;
        end
        S_RHI: if (phase_end) begin
          if (red_left != 3'd0 && win < WIN_LAST) begin
            dev_sclk <= 1'b0;  pcnt <= P_LO;  state <= S_RLO;
            red_left <= red_left - 3'd1;  red_done <= red_done + 3'd1;
          end else begin
            wcnt <= '0;  state <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (sdat_s) begin
            bit_left <= 5'd16 - {2'b00, red_done};  shreg <= '0;
            dev_sclk <= 1'b0;  pcnt <= P_LO;  state <= S_DLO;
          end else if (wcnt == CNV_LAST) begin
            timeout_err <= 1'b1;  state <= S_IDLE;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        S_DLO: if (phase_end) begin
          shreg <= {shreg[14:0], sdat_s};  bit_left <= bit_left - 5'd1;
          dev_sclk <= 1'b1;  pcnt <= P_HI;  state <= S_DHI;
        end
        S_DHI: if (phase_end) begin
          if (bit_left == 5'd0) begin
            result <= shreg << red_done;  result_valid <= 1'b1;  state <= S_IDLE;
          end else begin
            dev_sclk <= 1'b0;  pcnt <= P_LO;  state <= S_DLO;
          end
        end
        S_YH1: if (phase_end) begin
          samp_a <= sdat_s;  dev_sclk <= 1'b0;  pcnt <= P_LO;  state <= S_YLO;
        end
        S_YLO: if (phase_end) begin
          samp_b <= sdat_s;  dev_sclk <= 1'b1;  pcnt <= P_HI;  state <= S_YH2;
        end
        S_YH2: if (phase_end) begin
          if (samp_a && samp_b && !sdat_s) begin
            sync_done <= 1'b1;  red_done <= '0;  wcnt <= '0;  state <= S_WAIT;
          end else if (tries == TRY_LAST) begin
            timeout_err <= 1'b1;  state <= S_IDLE;
          end else begin
            tries <= tries + 1'b1;  pcnt <= P_HI;  state <= S_YH1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module edge_conv_host_chk #(
  parameter int HIGH_CYC   = 6,
  parameter int LOW_CYC    = 6,
  parameter int WINDOW_CYC = 128
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sclk,
  input logic       busy,
  input logic [1:0] addr,
  input logic       valid,
  input logic       tmo,
  input logic       sdone,
  input logic       req,
  input logic       sync_req,
  input logic       in_red,
  input logic       in_wait,
  input logic       in_sync
);
  logic        sp, bp;
  logic [15:0] run, winc;
  logic [3:0]  nred;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp <= 1'b1;  bp <= 1'b0;  run <= 16'(HIGH_CYC + LOW_CYC);  winc <= '0;  nred <= '0;
    end else begin
      sp <= sclk;  bp <= busy;
      if (sclk != sp) run <= 16'd1;
      else if (run != 16'hFFFF) run <= run + 16'd1;
      if (busy && !bp) winc <= 16'd1;
      else if (winc != 16'hFFFF) winc <= winc + 16'd1;
      if (busy && !bp) nred <= '0;
      else if (in_red && sp && !sclk) nred <= nred + 4'd1;
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (sclk && !busy && !valid && !tmo && !sdone));
  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(addr));
  // R3
  red_limit_chk: assert property (@(posedge clk) disable iff (!rst_n) nred <= 4'd6);
  // R3
  red_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_red && sp && !sclk) |-> (winc <= 16'(WINDOW_CYC)));
  // R4
  wait_high_chk: assert property (@(posedge clk) disable iff (!rst_n) in_wait |-> sclk);
  // R5
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) valid |=> !valid);
  // R6
  tmo_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) tmo |-> !valid);
  // R7
  low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && !sp) |-> (run >= 16'(LOW_CYC)));
  // R7
  high_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk && sp) |-> (run >= 16'(HIGH_CYC)));
  // R9
  req_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req) |=> (busy && !in_sync));
  // R8
  sync_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !req && sync_req) |=> in_sync);
endmodule

bind edge_conv_host edge_conv_host_chk #(
  .HIGH_CYC(HIGH_CYC), .LOW_CYC(LOW_CYC), .WINDOW_CYC(WINDOW_CYC)
) chk_i (
  .clk(clk), .rst_n(rst_n), .sclk(dev_sclk), .busy(busy), .addr(dev_addr),
  .valid(result_valid), .tmo(timeout_err), .sdone(sync_done), .req(req),
  .sync_req(sync_req), .in_red(in_red), .in_wait(in_wait), .in_sync(in_sync)
);

// File: tb/edge_conv_host_tb_top.sv
module edge_conv_host_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MWIN  = 140;
  localparam int MCONV = 150;
  localparam int NVEC  = 7;
  // {chan[9:8], res[7:3], expected reduction edges[2:0]}
  localparam logic [9:0] VEC [NVEC] = '{
    {2'd0, 5'd16, 3'd0}, {2'd1, 5'd10, 3'd6}, {2'd2, 5'd12, 3'd4},
    {2'd3, 5'd15, 3'd1}, {2'd2, 5'd8,  3'd6}, {2'd1, 5'd20, 3'd0},
    {2'd0, 5'd11, 3'd5}
  };

  logic clk = 1'b0, rst_n = 1'b0, mrst_n = 1'b0;
  logic req = 1'b0, sync_req = 1'b0, stuck = 1'b0;
  logic [1:0] req_chan = '0;
  logic [4:0] req_res = 5'd16;
  logic dev_sdat, dev_sclk, busy, result_valid, sync_done, timeout_err;
  logic [1:0] dev_addr;
  logic [15:0] result;
  int n_chk = 0, n_bad = 0, falls = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_conv_host #(.HIGH_CYC(6), .LOW_CYC(6), .WINDOW_CYC(128), .CONV_MAX(400),
                   .SYNC_TRIES(64)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .req_chan(req_chan), .req_res(req_res),
    .sync_req(sync_req), .dev_sdat(dev_sdat), .dev_sclk(dev_sclk), .dev_addr(dev_addr),
    .busy(busy), .result(result), .result_valid(result_valid), .sync_done(sync_done),
    .timeout_err(timeout_err));

  function automatic logic [15:0] mval(input logic [1:0] ch);
    case (ch)
      2'd0: mval = 16'h7FFF;
      2'd1: mval = 16'h8000;
      2'd2: mval = 16'hA5C3;
      default: mval = 16'h1234;
    endcase
  endfunction

  // behavioural device model
  typedef enum logic [2:0] {M_SLEEP, M_WIN, M_CONV, M_READY, M_READ} mst_t;
  mst_t ms;
  logic msp, fsp;
  logic [1:0] m_addr;
  logic [15:0] rw;
  int red, wcnt, ccnt, left, conv_falls;
  wire m_fell = msp & ~dev_sclk;
  wire m_rose = ~msp & dev_sclk;

  always @(posedge clk) begin
    fsp <= dev_sclk;
    if (fsp && !dev_sclk) falls <= falls + 1;
  end

  always @(posedge clk) begin
    if (!mrst_n) begin
      ms <= M_SLEEP; dev_sdat <= 1'b1; msp <= 1'b1; red <= 0; conv_falls <= 0;
      left <= 0; m_addr <= '0; rw <= '0; wcnt <= 0; ccnt <= 0;
    end else begin
      msp <= dev_sclk;
      case (ms)
        M_SLEEP: if (m_fell) begin
          m_addr <= dev_addr; red <= 0; wcnt <= 0; ms <= M_WIN;
        end
        M_WIN: begin
          wcnt <= wcnt + 1;
          if (m_fell && red < 6) begin red <= red + 1; dev_sdat <= 1'b1; end
          if (m_rose) dev_sdat <= 1'b0;
          if (wcnt == MWIN - 1) begin ms <= M_CONV; ccnt <= 0; dev_sdat <= 1'b0; end
        end
        M_CONV: begin
          if (m_fell) conv_falls <= conv_falls + 1;
          if (!stuck) ccnt <= ccnt + 1;
          if (!stuck && ccnt == MCONV - 1) begin
            dev_sdat <= 1'b1; ms <= M_READY;
            rw <= mval(m_addr) >> red; left <= 16 - red;
          end
        end
        M_READY: if (m_fell) begin
          dev_sdat <= rw[left-1]; left <= left - 1; ms <= M_READ;
        end
        M_READ: begin
          if (m_fell) begin dev_sdat <= rw[left-1]; left <= left - 1; end
          else if (m_rose && left == 0) begin ms <= M_SLEEP; dev_sdat <= 1'b1; end
        end
        default: ms <= M_SLEEP;
      endcase
    end
  end

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  logic [15:0] got_res;
  int got_valid, got_tmo, got_sync, sync_before;

  task automatic wait_end(input int limit);
    got_valid = 0; got_tmo = 0; got_sync = 0; sync_before = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (sync_done) begin got_sync++; if (got_valid == 0) sync_before = 1; end
      if (result_valid) begin got_valid++; got_res = result; end
      if (timeout_err) got_tmo++;
      if (!busy && (got_valid != 0 || got_tmo != 0)) break;
    end
  endtask

  task automatic issue(input logic [1:0] ch, input logic [4:0] rs, input bit also_sync);
    @(negedge clk);
    req = 1'b1; req_chan = ch; req_res = rs; sync_req = also_sync;
    @(negedge clk);
    req = 1'b0; sync_req = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(dev_sclk === 1'b1 && busy === 1'b0 && result_valid === 1'b0 &&
          sync_done === 1'b0 && timeout_err === 1'b0, "R1", {dev_sclk, busy, result_valid}, 3'b100);
    rst_n = 1'b1; mrst_n = 1'b1;
    @(negedge clk);
    check(dev_sclk === 1'b1 && busy === 1'b0, "R1", {dev_sclk, busy}, 2'b10);

    for (int v = 0; v < NVEC; v++) begin
      int f0;
      logic [1:0] ch;
      logic [2:0] er;
      ch = VEC[v][9:8]; er = VEC[v][2:0];
      f0 = falls;
      issue(ch, VEC[v][7:3], 1'b0);
      // R2 address lines carry the channel while busy
      check(dev_addr === ch && busy === 1'b1, "R2", dev_addr, ch);
      wait_end(3000);
      repeat (2) @(negedge clk);
      check(m_addr === ch, "R2", m_addr, ch);
      // R3 reduction edges and total edge count
      check(red == er, "R3", red, er);
      check(falls - f0 == 17, "R3", falls - f0, 17);
      // R4 no edge while converting
      check(conv_falls == 0, "R4", conv_falls, 0);
      // R5 left-aligned result, single strobe
      check(got_valid == 1 && got_res === (mval(ch) & (16'hFFFF << er)), "R5",
            got_res, mval(ch) & (16'hFFFF << er));
      check(ms == M_SLEEP, "R5", ms, M_SLEEP);
    end

    // R9 request while busy is ignored
    begin
      int f0;
      f0 = falls;
      issue(2'd0, 5'd16, 1'b0);
      repeat (20) @(negedge clk);
      req = 1'b1; req_chan = 2'd3; req_res = 5'd10; sync_req = 1'b1;
      @(negedge clk);
      req = 1'b0; sync_req = 1'b0;
      repeat (100) @(negedge clk);
      check(dev_addr === 2'd0, "R2", dev_addr, 2'd0);
      wait_end(3000);
      repeat (30) @(negedge clk);
      check(got_valid == 1 && got_res === 16'h7FFF && !result_valid, "R9", got_res, 16'h7FFF);
      check(falls - f0 == 17 && got_sync == 0, "R9", falls - f0, 17);
    end

    // R9 simultaneous conversion and resync requests: conversion wins
    begin
      int f0;
      f0 = falls;
      issue(2'd1, 5'd12, 1'b1);
      wait_end(3000);
      repeat (2) @(negedge clk);
      check(got_sync == 0, "R9", got_sync, 0);
      check(got_valid == 1 && got_res === (16'h8000 & 16'hFFF0), "R9", got_res, 16'h8000);
      check(falls - f0 == 17 && red == 4, "R9", falls - f0, 17);
    end

    // R6 conversion timeout
    stuck = 1'b1;
    issue(2'd2, 5'd16, 1'b0);
    wait_end(3000);
    check(got_tmo == 1 && got_valid == 0, "R6", {got_tmo[7:0], got_valid[7:0]}, 16'h0100);
    @(negedge clk);
    check(dev_sclk === 1'b1 && busy === 1'b0 && timeout_err === 1'b0, "R6", {dev_sclk, busy}, 2'b10);
    stuck = 1'b0; mrst_n = 1'b0;
    repeat (2) @(negedge clk);
    mrst_n = 1'b1;

    // R8 resync after host reset in the middle of a read
    issue(2'd2, 5'd16, 1'b0);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (ms == M_READ && left == 9) break;
    end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(dev_sclk === 1'b1 && busy === 1'b0, "R1", {dev_sclk, busy}, 2'b10);
    rst_n = 1'b1;
    @(negedge clk);
    sync_req = 1'b1; req_chan = 2'd3;
    @(negedge clk);
    sync_req = 1'b0;
    wait_end(6000);
    check(got_sync == 1 && sync_before == 1, "R8", got_sync, 1);
    check(got_valid == 1 && got_res === 16'h1234, "R8", got_res, 16'h1234);
    check(conv_falls == 0, "R4", conv_falls, 0);

    // R8 resync on an idle device finds the start in the first triple
    repeat (5) @(negedge clk);
    begin
      int f0;
      f0 = falls;
      @(negedge clk);
      sync_req = 1'b1; req_chan = 2'd0;
      @(negedge clk);
      sync_req = 1'b0;
      wait_end(6000);
      check(got_sync == 1 && got_res === 16'h7FFF && got_valid == 1, "R8", got_res, 16'h7FFF);
      check(falls - f0 == 17, "R8", falls - f0, 17);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule